// File: doc/BRIEF.md
# Signed-Magnitude Adder-Subtractor

This unit adds or subtracts two operands that are each a sign bit plus a W-bit magnitude. A one-cycle start pulse captures the operands and the add/subtract command. A short sequence then runs on a single parallel adder whose B input goes through a controllable complementer. The complement-select line also drives the adder's carry-in, so one adder produces either A + B or A − B.

A subtract command flips B's sign first, so the operation becomes an addition. If the effective signs agree, the magnitudes are added and the adder's carry-out is reported as overflow. If they differ, the unit forms A − B and keeps the carry-out as a borrow flag E. When E is clear (A < B), the same adder takes the two's complement of the difference in one extra cycle and the sign is inverted. The result is always correctly signed, and a zero magnitude is never reported as negative.

Results appear on registered outputs together with a one-cycle done pulse. They hold until the following operation completes.

Top module: `sm_addsub`

## Requirements
- R1: With `op_sub`=1, the sign of B is inverted before any other step, so A − B is computed as A + (−B). With `op_sub`=0, B is used as given.
- R2: When A's sign equals B's effective sign, `res_mag` is (a_mag + b_mag) mod 2^W and `res_sign` equals `a_sign`, except as stated in R6.
- R3: On the equal-sign path, `res_ovf` equals the carry out of bit W−1 of the magnitude sum.
- R4: When the signs differ and a_mag ≥ b_mag, `res_mag` is a_mag − b_mag and `res_sign` equals `a_sign`, except as stated in R6.
- R5: When the signs differ and a_mag < b_mag, `res_mag` is b_mag − a_mag and `res_sign` is the inverse of `a_sign`.
- R6: Whenever `res_mag` is zero and `res_ovf` is 0, `res_sign` is 0. This includes (−0)+(−0) and any difference of equal magnitudes.
- R7: On the differing-sign path, `res_ovf` is 0.
- R8: `done` is high for exactly one cycle. Counting the rising edge that samples `start` as edge 0, `done` rises after edge 2. When R5 applies, it rises after edge 3 instead.
- R9: `res_sign`, `res_mag` and `res_ovf` change only on the edge that raises `done`. They hold their values until the next result.
- R10: While `rst` is high at a rising edge, the outputs are cleared: `done`, `res_sign` and `res_ovf` are 0 and `res_mag` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that captures the operands (ignored while busy) |
| op_sub | input | 1 | 1 = subtract B from A, 0 = add |
| a_sign | input | 1 | Sign of A (1 = negative) |
| a_mag | input | W | Magnitude of A |
| b_sign | input | 1 | Sign of B (1 = negative) |
| b_mag | input | W | Magnitude of B |
| res_sign | output | 1 | Result sign |
| res_mag | output | W | Result magnitude |
| res_ovf | output | 1 | Magnitude overflow |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
A wrong borrow flag or a stale working sign causes visible errors. A difference with B larger than A comes out either uncomplemented or with the wrong sign, or the recomplement cycle is skipped. The skipped cycle moves `done` one edge early, and the bench checks it against the exact expected edge. A forgotten zero fix-up shows as a negative zero on the same `done` pulse. An overflow flag leaking from the add path shows on the next difference result. Operand pairs of equal magnitude, both sign orders, and sums that reach 2^W put every branch on the ports within four edges of `start`.

// File: rtl/sm_pkg.sv
package sm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXEC   = 2'd1,
        ST_RECOMP = 2'd2,
        ST_FIN    = 2'd3
    } sm_state_e;

    typedef enum logic {
        PATH_ADD  = 1'b0,
        PATH_DIFF = 1'b1
    } sm_path_e;

    function automatic logic eff_sign(input logic sgn, input logic sub);
        return sgn ^ sub;
    endfunction

    function automatic sm_path_e path_of(input logic sa, input logic sb_eff);
        return (sa != sb_eff) ? PATH_DIFF : PATH_ADD;
    endfunction

endpackage

// File: rtl/sm_cpladd.sv
module sm_cpladd #(
    parameter int W = 8
) (
    input  logic [W-1:0] add_a,
    input  logic [W-1:0] add_b,
    input  logic         inv_b,
    output logic [W-1:0] add_sum,
    output logic         add_cout
);
    localparam int WE = W + 1;

    logic [W-1:0]  b_sel;
    logic [WE-1:0] total;

    always_comb begin
        b_sel = inv_b ? ~add_b : add_b;
        total = {1'b0, add_a} + {1'b0, b_sel} + {{W{1'b0}}, inv_b};
    end

    assign add_sum  = total[W-1:0];
    assign add_cout = total[W];
endmodule

// File: rtl/sm_seq.sv
module sm_seq
    import sm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  sm_path_e  path,
    input  logic      borrow_n,
    output sm_state_e state
);
    sm_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:   if (start) nxt = ST_EXEC;
            ST_EXEC:   nxt = (path == PATH_DIFF && !borrow_n) ? ST_RECOMP : ST_FIN;
            ST_RECOMP: nxt = ST_FIN;
            ST_FIN:    nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    AST_RECOMP_THEN_FIN: assert property (@(posedge clk) disable iff (rst)
        state == ST_RECOMP |=> state == ST_FIN);                 // R5
    AST_ADD_NO_RECOMP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && path == PATH_ADD) |=> state == ST_FIN); // R8
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
    import sm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         op_sub,
    input  logic         a_sign,
    input  logic [W-1:0] a_mag,
    input  logic         b_sign,
    input  logic [W-1:0] b_mag,
    output logic         res_sign,
    output logic [W-1:0] res_mag,
    output logic         res_ovf,
    output logic         done
);
    localparam logic [W-1:0] MAG_ZERO = '0;

    sm_state_e    state;
    sm_path_e     path_q;
    logic         sa_q, sbe_q, wsign_q, e_q, wovf_q;
    logic [W-1:0] acc_q, bop_q;

    logic [W-1:0] x_a, x_b, x_sum;
    logic         x_inv, x_cout;

    // Operand steering for the shared adder: difference/sum in EXEC,
    // 0 + ~acc + 1 (two's complement) in RECOMP.
    always_comb begin
        x_a   = acc_q;
        x_b   = bop_q;
        x_inv = (path_q == PATH_DIFF);
        if (state == ST_RECOMP) begin
            x_a   = MAG_ZERO;
            x_b   = acc_q;
            x_inv = 1'b1;
        end
    end

    sm_cpladd #(.W(W)) u_add (
        .add_a   (x_a),
        .add_b   (x_b),
        .inv_b   (x_inv),
        .add_sum (x_sum),
        .add_cout(x_cout)
    );

    sm_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .path    (path_q),
        .borrow_n(x_cout),
        .state   (state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            path_q  <= PATH_ADD;
            sa_q    <= 1'b0;
            sbe_q   <= 1'b0;
            wsign_q <= 1'b0;
            e_q     <= 1'b0;
            wovf_q  <= 1'b0;
            acc_q   <= MAG_ZERO;
            bop_q   <= MAG_ZERO;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    sa_q   <= a_sign;
                    sbe_q  <= eff_sign(b_sign, op_sub);
                    path_q <= path_of(a_sign, eff_sign(b_sign, op_sub));
                    acc_q  <= a_mag;
                    bop_q  <= b_mag;
                end
                ST_EXEC: begin
                    acc_q   <= x_sum;
                    e_q     <= x_cout;
                    wsign_q <= sa_q;
                    wovf_q  <= (path_q == PATH_ADD) ? x_cout : 1'b0;
                end
                ST_RECOMP: begin
                    acc_q   <= x_sum;
                    wsign_q <= ~wsign_q;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_sign <= 1'b0;
            res_mag  <= MAG_ZERO;
            res_ovf  <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= (state == ST_FIN);
            if (state == ST_FIN) begin
                res_mag  <= acc_q;
                res_ovf  <= wovf_q;
                res_sign <= (acc_q == MAG_ZERO && !wovf_q) ? 1'b0 : wsign_q;
            end
        end
    end

    AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (rst)
        done |-> !(res_sign && res_mag == MAG_ZERO && !res_ovf));    // R6
    AST_DIFF_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        (done && sa_q != sbe_q) |-> !res_ovf);                       // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                             // R8
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(res_mag) && $stable(res_sign) && $stable(res_ovf))); // R9
    AST_BORROW_PATH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECOMP) |-> (path_q == PATH_DIFF && !e_q));     // R5
endmodule

// File: tb/sim_sm_addsub.sv
module sim_sm_addsub;
    localparam int W = 8;
    localparam int MAXV = (1 << W) - 1;

    typedef struct {
        logic         s;
        logic [W-1:0] m;
        logic         o;
        int           t_done;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, op_sub = 1'b0, a_sign = 1'b0, b_sign = 1'b0;
    logic [W-1:0] a_mag = '0, b_mag = '0;
    logic res_sign, res_ovf, done;
    logic [W-1:0] res_mag;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    exp_t sb[$];
    bit finished = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sm_addsub #(.W(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .op_sub(op_sub),
        .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign), .b_mag(b_mag),
        .res_sign(res_sign), .res_mag(res_mag), .res_ovf(res_ovf), .done(done)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Driver: compute expectation from the requirements, push, then pulse start.
    task automatic apply(input logic as, input int am, input logic sub,
                         input logic bs, input int bm);
        exp_t e;
        logic bse;
        int   sum;
        bse = bs ^ sub;                                   // R1
        if (as == bse) begin
            sum   = am + bm;
            e.m   = sum[W-1:0];                           // R2
            e.o   = (sum > MAXV);                         // R3
            e.s   = as;
            e.tag = "R2";
            e.t_done = cyc + 3;                           // R8
        end else if (am >= bm) begin
            e.m   = W'(am - bm);                          // R4
            e.o   = 1'b0;                                 // R7
            e.s   = as;
            e.tag = "R4";
            e.t_done = cyc + 3;
        end else begin
            e.m   = W'(bm - am);                          // R5
            e.o   = 1'b0;
            e.s   = ~as;
            e.tag = "R5";
            e.t_done = cyc + 4;
        end
        if (e.m == '0 && !e.o) e.s = 1'b0;                // R6
        sb.push_back(e);
        a_sign = as; a_mag = W'(am); b_sign = bs; b_mag = W'(bm);
        op_sub = sub; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        a_mag = ~a_mag; b_mag = ~b_mag;                   // operands must not matter once captured
        repeat (6) @(negedge clk);
    endtask

    // Monitor: pop and compare on every done, then check the pulse ends and results hold.
    bit           chk_next = 0;
    logic         h_s, h_o;
    logic [W-1:0] h_m;
    always @(negedge clk) begin
        if (!rst) begin
            if (chk_next) begin
                chk_next = 0;
                checks++;
                if (done || res_mag != h_m || res_sign != h_s || res_ovf != h_o) begin
                    fails++;
                    $display("FAIL R8/R9 after done: done=%0b out=%0b/%0d/%0b exp done=0 out=%0b/%0d/%0b",
                             done, res_sign, res_mag, res_ovf, h_s, h_m, h_o);
                end
            end
            if (done) begin
                exp_t e;
                checks++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL R8 unexpected done: act=1 exp=0");
                end else begin
                    e = sb.pop_front();
                    if (res_sign !== e.s || res_mag !== e.m || res_ovf !== e.o || cyc != e.t_done) begin
                        fails++;
                        $display("FAIL %s (R8 timing) act s=%0b m=%0d o=%0b t=%0d exp s=%0b m=%0d o=%0b t=%0d",
                                 e.tag, res_sign, res_mag, res_ovf, cyc, e.s, e.m, e.o, e.t_done);
                    end
                end
                h_s = res_sign; h_m = res_mag; h_o = res_ovf;
                chk_next = 1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: act=hung exp=finished");
            report();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        checks++;                                          // R10
        if (done !== 1'b0 || res_sign !== 1'b0 || res_ovf !== 1'b0 || res_mag !== '0) begin
            fails++;
            $display("FAIL R10 reset: act %0b/%0b/%0b/%0d exp 0/0/0/0", done, res_sign, res_ovf, res_mag);
        end
        rst = 1'b0;
        @(negedge clk);

        apply(0, 5, 0, 0, 3);       // R2: +5 + +3 = +8
        apply(1, 5, 0, 1, 3);       // R2: -5 + -3 = -8
        apply(0, 5, 0, 1, 3);       // R4: +5 + -3 = +2
        apply(0, 3, 0, 1, 5);       // R5: +3 + -5 = -2
        apply(1, 3, 0, 0, 5);       // R5: -3 + +5 = +2
        apply(0, 9, 1, 0, 4);       // R1: +9 - +4 = +5
        apply(0, 4, 1, 1, 9);       // R1: +4 - -9 = +13
        apply(0, 5, 1, 0, 5);       // R6: +5 - +5 = +0
        apply(1, 5, 1, 1, 5);       // R6: -5 - -5 = +0
        apply(1, 0, 0, 1, 0);       // R6: -0 + -0 = +0
        apply(0, 200, 0, 0, 100);   // R3: overflow
        apply(1, 200, 1, 0, 100);   // R3: -200 - +100 overflows
        apply(0, 255, 0, 0, 1);     // R3: wraps to 0 with overflow
        apply(0, 255, 1, 0, 0);     // R7: difference path, no overflow
        apply(1, 0, 1, 1, 255);     // R5: -0 - -255 = +255
        for (int i = 0; i < 300; i++)
            apply(1'($urandom), int'($urandom_range(0, MAXV)), 1'($urandom),
                  1'($urandom), int'($urandom_range(0, MAXV)));

        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R8 missing done: act pending=%0d exp 0", sb.size());
        end
        finished = 1;
        report();
    end
endmodule